// File: doc/BRIEF.md
# Quasi-Resonant Valley Selection Controller

This block picks the moment at which a quasi-resonant flyback controller turns its power switch back on. After each demagnetisation of the transformer the drain voltage rings, and an external zero-crossing comparator marks every minimum of that ringing with a valley pulse. The block counts those pulses and issues a one-cycle turn-on request at a valley number. That number depends on the active dimming step and on whether the mains is in the high-line range.

Deeper dimming steps wait for later valleys, which lowers the switching frequency. The high-line range adds one valley to every step. At the lowest step, the block also waits a fixed dead time after the chosen valley before it issues the request. If the ringing dies out before the wanted valley arrives, a timeout forces the request so that switching never stalls.

The block also contains the high-line detector. It uses two line-sense comparator flags: one flag for "above the upper threshold" and one for "below the lower threshold". High line is entered at once and left only after a filter time. All timing runs from a 1 µs tick.

Top module: `qr_valley_ctrl`

## Requirements
- R1: With high_line low, the request follows valley 1 for dim_step 0 (full light), valley 2 for dim_step 1 and valley 5 for dim_step 2.
- R2: With high_line high, the request follows valley 2 for dim_step 0, valley 3 for dim_step 1 and valley 6 for dim_step 2.
- R3: dim_step 3 (lowest light) uses the dim_step 2 valley and then waits DEAD_US ticks. The request follows the edge that samples the DEAD_US-th tick_us counted after the target valley.
- R4: dim_step and high_line are sampled only at the edge that samples demag_start. A change in the middle of a switching cycle does not move that cycle's target. cur_valley shows the target in force.
- R5: demag_start clears the valley count. Each switching cycle gives at most one request. Valleys after the request, and valleys before the first demag_start after reset, give none.
- R6: high_line is high in the cycle after an edge that samples vs_above_hi high.
- R7: high_line falls after the edge that samples the FILTER_US-th tick_us of an unbroken run of vs_below_lo. Any sample with vs_below_lo low restarts the count.
- R8: If the target valley has not arrived by the TIMEOUT_US-th tick_us after demag_start, turn_on_req and forced_on pulse together for one cycle.
- R9: After reset, turn_on_req, forced_on and high_line are 0 and cur_valley is 1.
- R10: turn_on_req is a single-cycle pulse in the cycle after the edge that samples the target valley pulse (for dim_step 0 to 2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_us | input | 1 | One-cycle strobe every microsecond |
| demag_start | input | 1 | Start of a switching cycle (demagnetisation begins) |
| valley_pulse | input | 1 | One-cycle strobe per detected valley |
| dim_step | input | 2 | Dimming step: 0=100 %, 1=70 %, 2=25 %, 3=5 % |
| vs_above_hi | input | 1 | Line sense above the upper threshold |
| vs_below_lo | input | 1 | Line sense below the lower threshold |
| turn_on_req | output | 1 | Turn-on request pulse |
| forced_on | output | 1 | Marks a request issued by the timeout |
| high_line | output | 1 | High-line range flag |
| cur_valley | output | 4 | Valley number locked for the current cycle |

## Verification
Two situations are hard to reach. The first is leaving high line: vs_below_lo must stay high for a whole filter window with no break. The second is that window restarting after a brief return above the threshold. The stimulus drops the flag briefly just short of the window and confirms that high_line stays set. It then holds the flag through a full window. A reduced FILTER_US keeps this short. A mid-cycle step change and a silent cycle that ends in a forced request are also driven. The behavioural model is compared on every clock.

// File: rtl/qr_valley_pkg.sv
// Shared types and the valley choice rule for the valley controller.
package qr_valley_pkg;

    localparam int VALLEY_W = 4;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_HUNT = 2'd1,
        SEQ_DEAD = 2'd2
    } seq_state_t;

    // Valley number for a dimming step; high line adds hl_extra valleys.
    function automatic logic [VALLEY_W-1:0] pick_valley(
        input logic [1:0]          step,
        input logic                hl,
        input logic [VALLEY_W-1:0] hl_extra
    );
        logic [VALLEY_W-1:0] base;
        case (step)
            2'd0:    base = VALLEY_W'(1);
            2'd1:    base = VALLEY_W'(2);
            default: base = VALLEY_W'(5);
        endcase
        return hl ? base + hl_extra : base;
    endfunction

endpackage

// File: rtl/line_range_det.sv
// High-line detector with hysteresis.
// Sets at once when the line sense is above the upper threshold.
// Clears only after FILTER_US microsecond ticks of continuous below-lower-threshold.
// Assumes tick_us is a one-cycle strobe and both flags are already synchronised.
module line_range_det #(
    parameter int FILTER_US = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_us,
    input  logic vs_above_hi,
    input  logic vs_below_lo,
    output logic high_line
);
    localparam int FW = $clog2(FILTER_US + 1);

    logic [FW-1:0] filt_cnt;

    // Range flag and its low-side filter counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_line <= 1'b0;
            filt_cnt  <= '0;
        end else if (vs_above_hi) begin
            high_line <= 1'b1;
            filt_cnt  <= '0;
        end else if (high_line && vs_below_lo) begin
            if (tick_us) begin
                if (filt_cnt == FW'(FILTER_US - 1)) begin
                    high_line <= 1'b0;
                    filt_cnt  <= '0;
                end else begin
                    filt_cnt <= filt_cnt + 1'b1;
                end
            end
        end else begin
            filt_cnt <= '0;
        end
    end

    assert_enter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vs_above_hi |=> high_line);
    assert_leave_filtered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(high_line) |-> ($past(vs_below_lo) && $past(tick_us)));

endmodule

// File: rtl/valley_target_sel.sv
// Locks the target valley and the dead-time flag at each cycle start.
// Assumes demag_start marks the first clock of a switching cycle.
module valley_target_sel
    import qr_valley_pkg::*;
#(
    parameter int HL_EXTRA = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                demag_start,
    input  logic [1:0]          dim_step,
    input  logic                high_line,
    output logic [VALLEY_W-1:0] target_valley,
    output logic                add_dead
);
    // Capture step and line range only at the cycle boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_valley <= pick_valley(2'd0, 1'b0, VALLEY_W'(HL_EXTRA));
            add_dead      <= 1'b0;
        end else if (demag_start) begin
            target_valley <= pick_valley(dim_step, high_line, VALLEY_W'(HL_EXTRA));
            add_dead      <= (dim_step == 2'd3);
        end
    end

    assert_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !demag_start |=> ($stable(target_valley) && $stable(add_dead)));

endmodule

// File: rtl/valley_seq.sv
// Per-cycle sequencer.
// Counts valleys after demag_start and requests turn-on at the target.
// Optionally waits a dead time first, and forces a request on timeout.
// Assumes valley_pulse and tick_us are one-cycle strobes.
module valley_seq
    import qr_valley_pkg::*;
#(
    parameter int DEAD_US    = 40,
    parameter int TIMEOUT_US = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_us,
    input  logic                demag_start,
    input  logic                valley_pulse,
    input  logic [VALLEY_W-1:0] target_valley,
    input  logic                add_dead,
    output logic                turn_on_req,
    output logic                forced_on
);
    localparam int DW = $clog2(DEAD_US + 1);
    localparam int TW = $clog2(TIMEOUT_US + 1);

    seq_state_t          state;
    logic [VALLEY_W-1:0] vcnt;
    logic [DW-1:0]       dcnt;
    logic [TW-1:0]       tmo;
    logic                hit;

    // Target valley seen in this clock.
    always_comb hit = valley_pulse && ((vcnt + 1'b1) == target_valley);

    // Cycle state machine with valley, dead-time and timeout counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SEQ_IDLE;
            vcnt        <= '0;
            dcnt        <= '0;
            tmo         <= '0;
            turn_on_req <= 1'b0;
            forced_on   <= 1'b0;
        end else begin
            turn_on_req <= 1'b0;
            forced_on   <= 1'b0;
            if (demag_start) begin
                state <= SEQ_HUNT;
                vcnt  <= '0;
                tmo   <= '0;
                dcnt  <= '0;
            end else begin
                case (state)
                    SEQ_HUNT: begin
                        if (valley_pulse) vcnt <= vcnt + 1'b1;
                        if (hit) begin
                            if (add_dead) begin
                                state <= SEQ_DEAD;
                                dcnt  <= '0;
                            end else begin
                                state       <= SEQ_IDLE;
                                turn_on_req <= 1'b1;
                            end
                        end else if (tick_us) begin
                            if (tmo == TW'(TIMEOUT_US - 1)) begin
                                state       <= SEQ_IDLE;
                                turn_on_req <= 1'b1;
                                forced_on   <= 1'b1;
                            end else begin
                                tmo <= tmo + 1'b1;
                            end
                        end
                    end
                    SEQ_DEAD: begin
                        if (tick_us) begin
                            if (dcnt == DW'(DEAD_US - 1)) begin
                                state       <= SEQ_IDLE;
                                turn_on_req <= 1'b1;
                            end else begin
                                dcnt <= dcnt + 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_one_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && !demag_start) |=> !turn_on_req);
    assert_forced_is_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        forced_on |-> turn_on_req);
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_HUNT) |-> (vcnt < target_valley));
    assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        turn_on_req |=> !turn_on_req);

endmodule

// File: rtl/qr_valley_ctrl.sv
// Top of the quasi-resonant valley selection controller.
// Joins the line-range detector, the per-cycle target lock and the sequencer.
// Assumes all inputs are synchronous to clk.
module qr_valley_ctrl
    import qr_valley_pkg::*;
#(
    parameter int FILTER_US  = 25000,
    parameter int DEAD_US    = 40,
    parameter int TIMEOUT_US = 40,
    parameter int HL_EXTRA   = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_us,
    input  logic                demag_start,
    input  logic                valley_pulse,
    input  logic [1:0]          dim_step,
    input  logic                vs_above_hi,
    input  logic                vs_below_lo,
    output logic                turn_on_req,
    output logic                forced_on,
    output logic                high_line,
    output logic [VALLEY_W-1:0] cur_valley
);
    logic add_dead;

    line_range_det #(.FILTER_US(FILTER_US)) u_line (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .vs_above_hi(vs_above_hi), .vs_below_lo(vs_below_lo),
        .high_line(high_line)
    );

    valley_target_sel #(.HL_EXTRA(HL_EXTRA)) u_sel (
        .clk(clk), .rst_n(rst_n), .demag_start(demag_start),
        .dim_step(dim_step), .high_line(high_line),
        .target_valley(cur_valley), .add_dead(add_dead)
    );

    valley_seq #(.DEAD_US(DEAD_US), .TIMEOUT_US(TIMEOUT_US)) u_seq (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us),
        .demag_start(demag_start), .valley_pulse(valley_pulse),
        .target_valley(cur_valley), .add_dead(add_dead),
        .turn_on_req(turn_on_req), .forced_on(forced_on)
    );

endmodule

// File: tb/qr_valley_ctrl_test.sv
module qr_valley_ctrl_test;
    localparam int FILT = 50;
    localparam int DEAD = 8;
    localparam int TMO  = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_us = 1'b0;
    logic demag_start = 1'b0;
    logic valley_pulse = 1'b0;
    logic [1:0] dim_step = 2'd0;
    logic vs_above_hi = 1'b0;
    logic vs_below_lo = 1'b0;
    logic turn_on_req, forced_on, high_line;
    logic [3:0] cur_valley;

    int checks = 0;
    int errors = 0;
    bit armed = 1'b0;
    bit done = 1'b0;
    string phase = "R9";

    qr_valley_ctrl #(.FILTER_US(FILT), .DEAD_US(DEAD), .TIMEOUT_US(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .demag_start(demag_start),
        .valley_pulse(valley_pulse), .dim_step(dim_step), .vs_above_hi(vs_above_hi),
        .vs_below_lo(vs_below_lo), .turn_on_req(turn_on_req), .forced_on(forced_on),
        .high_line(high_line), .cur_valley(cur_valley)
    );

    always #2.5 clk = ~clk;

    // Microsecond tick: every other clock.
    always @(negedge clk) tick_us <= ~tick_us;

    // Behavioural reference: expected outputs after each edge.
    int m_req = 0, m_forced = 0, m_hl = 0, m_val = 1, m_dead = 0;
    int m_fcnt = 0, m_state = 0, m_vc = 0, m_tmo = 0, m_dc = 0;

    function automatic int want_valley(int step, int hl);
        int v;
        v = (step == 0) ? 1 : (step == 1) ? 2 : 5;
        return v + hl;
    endfunction

    always @(posedge clk) begin
        int old_hl;
        if (!rst_n) begin
            m_req = 0; m_forced = 0; m_hl = 0; m_val = 1; m_dead = 0;
            m_fcnt = 0; m_state = 0; m_vc = 0; m_tmo = 0; m_dc = 0;
        end else begin
            old_hl = m_hl;
            m_req = 0; m_forced = 0;
            if (vs_above_hi) begin
                m_hl = 1; m_fcnt = 0;
            end else if (m_hl == 1 && vs_below_lo) begin
                if (tick_us) begin
                    m_fcnt++;
                    if (m_fcnt == FILT) begin m_hl = 0; m_fcnt = 0; end
                end
            end else m_fcnt = 0;
            if (demag_start) begin
                m_state = 1; m_vc = 0; m_tmo = 0; m_dc = 0;
                m_val = want_valley(dim_step, old_hl);
                m_dead = (dim_step == 3) ? 1 : 0;
            end else if (m_state == 1) begin
                if (valley_pulse) m_vc++;
                if (valley_pulse && m_vc == m_val) begin
                    if (m_dead == 1) begin m_state = 2; m_dc = 0; end
                    else begin m_state = 0; m_req = 1; end
                end else if (tick_us) begin
                    m_tmo++;
                    if (m_tmo == TMO) begin m_state = 0; m_req = 1; m_forced = 1; end
                end
            end else if (m_state == 2) begin
                if (tick_us) begin
                    m_dc++;
                    if (m_dc == DEAD) begin m_state = 0; m_req = 1; end
                end
            end
        end
    end

    task automatic check(string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", phase, what, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (armed && !done) begin
            check("turn_on_req", int'(turn_on_req), m_req);
            check("forced_on", int'(forced_on), m_forced);
            check("high_line", int'(high_line), m_hl);
            check("cur_valley", int'(cur_valley), m_val);
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic demag();
        @(negedge clk) demag_start = 1'b1;
        @(negedge clk) demag_start = 1'b0;
    endtask

    task automatic valleys(int n, int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) valley_pulse = 1'b1;
            @(negedge clk) valley_pulse = 1'b0;
            idle(gap);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        phase = "R9";
        check("reset req", int'(turn_on_req), 0);
        check("reset hl", int'(high_line), 0);
        check("reset valley", int'(cur_valley), 1);
        armed = 1'b1;
        phase = "R5";               // valleys with no cycle open: no request
        valleys(3, 2);
        phase = "R1";
        for (int s = 0; s < 3; s++) begin
            dim_step = 2'(s);
            demag();
            valleys(7, 2);          // R5: extra valleys past the target ignored
            idle(4);
        end
        phase = "R3";
        dim_step = 2'd3;
        demag();
        valleys(6, 1);
        idle(30);
        phase = "R4";               // step changes mid-cycle
        dim_step = 2'd2;
        demag();
        valleys(1, 1);
        dim_step = 2'd0;
        valleys(5, 1);
        idle(4);
        phase = "R8";               // no valleys at all: forced request
        demag();
        idle(80);
        phase = "R6";
        @(negedge clk) vs_above_hi = 1'b1;
        @(negedge clk) vs_above_hi = 1'b0;
        phase = "R2";
        for (int s = 0; s < 4; s++) begin
            dim_step = 2'(s);
            demag();
            valleys(8, 1);
            idle(30);
        end
        phase = "R7";               // brief break restarts the filter
        vs_below_lo = 1'b1;
        idle(2 * FILT - 6);
        vs_below_lo = 1'b0;
        idle(2);
        vs_below_lo = 1'b1;
        idle(2 * FILT - 6);
        check("held high", int'(high_line), 1);
        idle(20);
        check("released", int'(high_line), 0);
        vs_below_lo = 1'b0;
        phase = "R10";
        dim_step = 2'd1;
        demag();
        valleys(4, 3);
        idle(10);
        finish_run();
    end
endmodule